// File: doc/BRIEF.md
# Guarded Tightly-Coupled Data RAM

This block is a small data memory that answers at the bottom of the address space on a 32-bit load/store port. It sits beside the cache and the external memory path. The block claims an access only when the address falls inside its range. For an access it does not claim, it keeps its select output low, so that another target on the port can respond. Reads return a full word one clock after the request. Writes take effect at the request edge, one byte lane at a time under the byte enables.

The lowest bytes of the array hold a table of cached interrupt vectors. While the guard input is high, that window is write-protected, which catches stray stores through null pointers. Protection is checked separately for every enabled byte of a write. When a write has any enabled byte inside the window, those bytes are dropped and the block pulses a fault flag for one cycle. The fault pulse carries the offending address. Reads of the window are never restricted.

Top module: `guarded_sram`

## Requirements
- R1: `sel` is high in the same cycle exactly when `req_valid` is high and `req_addr` is below `MEM_BYTES` (default 1024, so 0x000 to 0x3FF). Otherwise it is low.
- R2: A claimed read makes `rd_valid` high for one cycle at the next clock edge. At that edge `rd_data` holds the addressed word, and `req_addr[1:0]` is ignored.
- R3: A claimed write updates only the byte lanes whose `req_be` bit is set. Lane i is `rd_data`/`req_wdata` bits 8i+7 to 8i, at byte address (`req_addr` with bits 1:0 replaced by i).
- R4: While `guard_en` is low, writes into the low window store normally and raise no fault.
- R5: While `guard_en` is high, every enabled byte whose byte address is below `GUARD_BYTES` (default 64, bytes 0x00 to 0x3F) is left unchanged.
- R6: Protection is decided per byte. In a word that straddles the window boundary, the enabled bytes at or above `GUARD_BYTES` are still written.
- R7: A claimed write with at least one blocked byte makes `fault` high for exactly the next cycle, with `fault_addr` equal to that write's `req_addr`. Any other cycle leaves `fault` low.
- R8: Reads inside the window return the stored data with `guard_en` high or low, and never raise `fault`.
- R9: An unclaimed request (not valid, or out of range) changes no stored byte, produces no `rd_valid` and no `fault`.
- R10: During and right after reset, `rd_valid` and `fault` are low and `rd_data` and `fault_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present on the port |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| guard_en | input | 1 | Write protection of the low window on |
| sel | output | 1 | Request claimed by this block |
| rd_valid | output | 1 | Read data valid this cycle |
| rd_data | output | 32 | Read data |
| fault | output | 1 | One-cycle pulse for a blocked write |
| fault_addr | output | 32 | Address of the blocked write |

## Verification
The bench builds the block with `GUARD_BYTES` set to 66 and `MEM_BYTES` left at 1024. With that window, the word at 0x40 straddles the boundary: its two low bytes are guarded and its two high bytes are not. With the default of 64 the boundary falls on a word edge, so the per-byte split could never show. A window that is not a multiple of four therefore brings the mixed case within reach. The same stimulus still covers whole guarded words, fully open words, the top word at 0x3FC and the first unclaimed address at 0x400.

// File: rtl/gsr_pkg.sv
package gsr_pkg;

    localparam int BUS_AW = 32;
    localparam int BUS_DW = 32;
    localparam int LANES  = BUS_DW / 8;
    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        logic              wr;
        logic [BUS_AW-1:0] addr;
        logic [LANES-1:0]  be;
        logic [BUS_DW-1:0] wdata;
    } acc_t;

    function automatic logic [BUS_AW-1:0] lane_byte_addr(
        input logic [BUS_AW-1:0] a,
        input int unsigned       lane
    );
        logic [1:0] l;
        l = lane[1:0];
        return {a[BUS_AW-1:2], l};
    endfunction

endpackage

// File: rtl/gsr_decode.sv
module gsr_decode
    import gsr_pkg::*;
#(
    parameter int MEM_BYTES   = 1024,
    parameter int GUARD_BYTES = 64,
    localparam int WORDS = MEM_BYTES / LANES,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             req_valid,
    input  acc_t             acc,
    input  logic             guard_en,
    output logic             hit,
    output op_e              op,
    output logic [IDX_W-1:0] word_idx,
    output logic [LANES-1:0] lane_wr,
    output logic             any_block
);

    logic [LANES-1:0] lane_guarded;

    assign hit      = req_valid && (acc.addr < BUS_AW'(MEM_BYTES));
    assign word_idx = acc.addr[IDX_W+1:2];

    always_comb begin
        if (!hit)        op = OP_NONE;
        else if (acc.wr) op = OP_WRITE;
        else             op = OP_READ;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
        assign lane_guarded[g] = guard_en &&
            (lane_byte_addr(acc.addr, g) < BUS_AW'(GUARD_BYTES));
        assign lane_wr[g] = (op == OP_WRITE) && acc.be[g] && !lane_guarded[g];
    end

    assign any_block = (op == OP_WRITE) && |(acc.be & lane_guarded);

endmodule

// File: rtl/gsr_lane.sv
module gsr_lane
    import gsr_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              re,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANE_W-1:0] wd,
    output logic [LANE_W-1:0] rd
);

    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[idx] <= wd;
    end

    always_ff @(posedge clk) begin
        if (rst)     rd <= '0;
        else if (re) rd <= cells[idx];
    end

endmodule

// File: rtl/gsr_fault.sv
module gsr_fault
    import gsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              blocked,
    input  logic [BUS_AW-1:0] addr,
    output logic              fault,
    output logic [BUS_AW-1:0] fault_addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fault      <= 1'b0;
            fault_addr <= '0;
        end else begin
            fault <= blocked;
            if (blocked) fault_addr <= addr;
        end
    end

endmodule

// File: rtl/guarded_sram.sv
module guarded_sram
    import gsr_pkg::*;
#(
    parameter int MEM_BYTES   = 1024,
    parameter int GUARD_BYTES = 64,
    localparam int WORDS = MEM_BYTES / LANES,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BUS_AW-1:0] req_addr,
    input  logic [LANES-1:0]  req_be,
    input  logic [BUS_DW-1:0] req_wdata,
    input  logic              guard_en,
    output logic              sel,
    output logic              rd_valid,
    output logic [BUS_DW-1:0] rd_data,
    output logic              fault,
    output logic [BUS_AW-1:0] fault_addr
);

    acc_t             acc;
    op_e              op;
    logic [IDX_W-1:0] word_idx;
    logic [LANES-1:0] lane_wr;
    logic             any_block;

    assign acc = '{wr: req_write, addr: req_addr, be: req_be, wdata: req_wdata};

    gsr_decode #(
        .MEM_BYTES  (MEM_BYTES),
        .GUARD_BYTES(GUARD_BYTES)
    ) decode_i (
        .req_valid(req_valid),
        .acc      (acc),
        .guard_en (guard_en),
        .hit      (sel),
        .op       (op),
        .word_idx (word_idx),
        .lane_wr  (lane_wr),
        .any_block(any_block)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_store
        gsr_lane #(.DEPTH(WORDS)) lane_i (
            .clk(clk),
            .rst(rst),
            .we (lane_wr[g]),
            .re (op == OP_READ),
            .idx(word_idx),
            .wd (acc.wdata[g*LANE_W +: LANE_W]),
            .rd (rd_data[g*LANE_W +: LANE_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) rd_valid <= 1'b0;
        else     rd_valid <= (op == OP_READ);
    end

    gsr_fault fault_i (
        .clk       (clk),
        .rst       (rst),
        .blocked   (any_block),
        .addr      (req_addr),
        .fault     (fault),
        .fault_addr(fault_addr)
    );

endmodule

// File: rtl/guarded_sram_chk.sv
module guarded_sram_chk #(
    parameter int MEM_BYTES = 1024
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic [31:0] req_addr,
    input logic        guard_en,
    input logic        sel,
    input logic        rd_valid,
    input logic        fault,
    input logic [31:0] fault_addr
);

    // R1
    sel_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !sel);

    // R1
    sel_range_chk: assert property (@(posedge clk) disable iff (rst)
        (req_addr >= 32'(MEM_BYTES)) |-> !sel);

    // R2
    read_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && !req_write) |=> rd_valid);

    // R8
    read_no_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && !req_write) |=> !fault);

    // R9
    unclaimed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !sel |=> (!rd_valid && !fault));

    // R7
    fault_source_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> ($past(sel && req_write && guard_en) && fault_addr == $past(req_addr)));

    // R10
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rd_valid && !fault));

endmodule

bind guarded_sram guarded_sram_chk #(.MEM_BYTES(MEM_BYTES)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .guard_en  (guard_en),
    .sel       (sel),
    .rd_valid  (rd_valid),
    .fault     (fault),
    .fault_addr(fault_addr)
);

// File: tb/guarded_sram_tb_top.sv
module guarded_sram_tb_top;

    localparam int MEMB  = 1024;
    localparam int GUARD = 66;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        guard_en = 1'b0;
    logic        sel, rd_valid, fault;
    logic [31:0] rd_data, fault_addr;

    int checks = 0;
    int errors = 0;

    logic [7:0] mem_m [0:MEMB-1];
    bit         known [0:MEMB-1];

    always #4 clk = ~clk;

    guarded_sram #(.MEM_BYTES(MEMB), .GUARD_BYTES(GUARD)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .guard_en(guard_en), .sel(sel), .rd_valid(rd_valid), .rd_data(rd_data),
        .fault(fault), .fault_addr(fault_addr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input string tag, input bit v, input bit w, input logic [31:0] a,
                       input logic [3:0] be, input logic [31:0] d, input bit g);
        bit          e_sel, e_rv, e_fault, all_known;
        logic [31:0] e_rd;
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = a; req_be = be;
        req_wdata = d; guard_en = g;
        e_sel = v && (a < MEMB);
        e_rv = e_sel && !w;
        e_fault = 1'b0;
        all_known = 1'b1;
        e_rd = '0;
        for (int i = 0; i < 4; i++) begin
            int ba;
            ba = int'({a[31:2], 2'(i)});
            if (e_rv) begin
                e_rd[8*i +: 8] = mem_m[ba];
                if (!known[ba]) all_known = 1'b0;
            end
            if (e_sel && w && be[i]) begin
                if (g && ba < GUARD) e_fault = 1'b1;
                else begin
                    mem_m[ba] = d[8*i +: 8];
                    known[ba] = 1'b1;
                end
            end
        end
        #1;
        check({tag, " sel"}, 32'(sel), 32'(e_sel));
        @(posedge clk);
        #1;
        check({tag, " rd_valid"}, 32'(rd_valid), 32'(e_rv));
        if (e_rv && all_known) check({tag, " rd_data"}, rd_data, e_rd);
        check({tag, " fault"}, 32'(fault), 32'(e_fault));
        if (e_fault) check({tag, " fault_addr"}, fault_addr, a);
    endtask

    task automatic wr(input string tag, input logic [31:0] a, input logic [3:0] be,
                      input logic [31:0] d, input bit g);
        cyc(tag, 1'b1, 1'b1, a, be, d, g);
    endtask

    task automatic rd(input string tag, input logic [31:0] a, input bit g);
        cyc(tag, 1'b1, 1'b0, a, 4'h0, 32'h0, g);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEMB; i++) begin
            known[i] = 1'b0;
            mem_m[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        // R10: outputs during reset
        check("R10 rd_valid", 32'(rd_valid), 0);
        check("R10 fault", 32'(fault), 0);
        check("R10 rd_data", rd_data, 0);
        check("R10 fault_addr", fault_addr, 0);
        @(negedge clk);
        rst = 1'b0;
        cyc("R10 idle", 1'b0, 1'b0, 32'h0, 4'h0, 32'h0, 1'b0);

        // R4: guard off, fill window and open words
        wr("R4 w00", 32'h000, 4'hF, 32'h11223344, 1'b0);
        wr("R4 w3C", 32'h03C, 4'hF, 32'hA5A5_5A5A, 1'b0);
        wr("R4 w40", 32'h040, 4'hF, 32'hCAFE_BABE, 1'b0);
        wr("R4 w44", 32'h044, 4'hF, 32'h0BAD_F00D, 1'b0);
        wr("R3 w100", 32'h100, 4'hF, 32'h89AB_CDEF, 1'b0);
        wr("R3 w3FC", 32'h3FC, 4'hF, 32'hDEAD_BEEF, 1'b0);
        // R2: readback, back to back
        rd("R2 r00", 32'h000, 1'b0);
        rd("R2 r3C", 32'h03C, 1'b0);
        rd("R2 r3FC", 32'h3FE, 1'b0);
        rd("R2 r100", 32'h101, 1'b0);

        // R3: partial writes, low address bits ignored
        wr("R3 be5", 32'h102, 4'b0101, 32'h1111_2222, 1'b0);
        rd("R3 rb5", 32'h100, 1'b0);
        wr("R3 be8", 32'h100, 4'b1000, 32'h7700_0000, 1'b0);
        rd("R3 rb8", 32'h100, 1'b0);

        // R5 R7: guard on, whole guarded word and a single guarded byte
        wr("R5 g00", 32'h000, 4'hF, 32'hFFFF_FFFF, 1'b1);
        wr("R7 g3C", 32'h03D, 4'b0001, 32'h0000_00EE, 1'b1);
        wr("R7 be0", 32'h000, 4'h0, 32'h0, 1'b1);
        // R6: straddling word, bytes 0x40/0x41 guarded, 0x42/0x43 written
        wr("R6 g40", 32'h040, 4'hF, 32'h1234_5678, 1'b1);
        wr("R6 g40hi", 32'h040, 4'b1100, 32'h9900_0000, 1'b1);
        wr("R6 g44", 32'h044, 4'hF, 32'h5555_AAAA, 1'b1);
        // R8: reads of the window with guard on
        rd("R8 r00", 32'h000, 1'b1);
        rd("R8 r3C", 32'h03C, 1'b1);
        rd("R6 r40", 32'h040, 1'b1);
        rd("R6 r44", 32'h044, 1'b1);

        // R9 R1: unclaimed requests
        wr("R9 w400", 32'h400, 4'hF, 32'h0000_0000, 1'b0);
        wr("R9 wfar", 32'h1000_0000, 4'hF, 32'h0000_0000, 1'b1);
        cyc("R9 novalid", 1'b0, 1'b1, 32'h000, 4'hF, 32'h0000_0000, 1'b0);
        rd("R1 r400", 32'h400, 1'b0);
        rd("R9 r00", 32'h000, 1'b0);
        rd("R9 r3FC", 32'h3FC, 1'b0);

        // R4: guard off again, window writable
        wr("R4 w00b", 32'h000, 4'hF, 32'h0F0E_0D0C, 1'b0);
        rd("R4 r00b", 32'h000, 1'b1);
        wr("R4 w40b", 32'h040, 4'b0011, 32'h0000_BEEF, 1'b0);
        rd("R4 r40b", 32'h040, 1'b0);
        cyc("R7 tail", 1'b0, 1'b0, 32'h0, 4'h0, 32'h0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule